// File: doc/BRIEF.md
# Shared-Memory Virtual Channel Queue Bank

This block holds a set of independent first-in first-out queues, one for each virtual channel of a link, inside one storage array. The array has a single write port and a single read port. Every queue owns a fixed region of the array, and all regions have the same power-of-two depth. A word's array address is the queue index placed above the queue's local pointer. Words enter through one enqueue channel that carries a queue index. Each queue has its own dequeue channel with a valid/ready handshake.

A round-robin arbiter gives the read port to one queue per cycle. A queue can be chosen when it still holds unread words and its output stage will have room for the returning word. The array's read data arrives one cycle after the read is issued and lands in a two-slot output buffer for that queue. This lets one queue alone stream a word every cycle. It also means a stalled consumer never loses data.

A queue's slot is released when its consumer takes the word, not when the array is read. The status outputs therefore show the true logical occupancy of each queue. Each queue reports full, empty and a free-slot count.

Top module: `mqf_bank`

## Requirements
- R1: While reset is held and right after it, every queue reports empty=1, full=0 and free=DEPTH. No dequeue valid is raised, and enq_ready is 1.
- R2: When the queue selected by enq_qid holds DEPTH words, enq_ready is 0. An offered word is then not stored, and it never appears on any dequeue port.
- R3: Each queue delivers its accepted words on its own dequeue port in the order they were accepted, with no word lost, duplicated or delivered to another queue.
- R4: After every clock edge, q_free of a queue (bits [i*CW +: CW], CW = clog2(DEPTH+1)) equals DEPTH minus (words accepted − words dequeued). full is 1 exactly when that count is 0, and empty is 1 exactly when it is DEPTH.
- R5: An accepted enqueue and a dequeue handshake on the same queue in the same cycle leave that queue's free count unchanged.
- R6: A word accepted in cycle T into an empty queue, with no other traffic and its consumer ready, is first offered on its dequeue port in cycle T+3.
- R7: A single active queue whose consumer is always ready delivers one word per cycle once the stream starts. Eight back-to-back enqueues in cycles T..T+7 are dequeued in cycles T+3..T+10.
- R8: Read-port grants rotate round-robin among eligible queues. A word enqueued into a waiting queue while another queue streams is offered no later than NQ+3 cycles after its acceptance.
- R9: While a dequeue port shows valid and its ready is low, valid stays high and the data stays unchanged.
- R10: A stalled or full queue does not block the delivery of other queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | An enqueue word is offered |
| enq_qid | input | QW | Target queue of the offered word |
| enq_data | input | W | Offered word |
| enq_ready | output | 1 | The target queue has a free slot |
| deq_valid | output | NQ | Per-queue word available |
| deq_ready | input | NQ | Per-queue consumer takes the word |
| deq_data | output | NQ*W | Per-queue head word, queue i at bits [i*W +: W] |
| q_full | output | NQ | Per-queue full flag |
| q_empty | output | NQ | Per-queue empty flag |
| q_free | output | NQ*CW | Per-queue free-slot count |

## Verification
A wrong pointer or region address shows up as a word that is out of order or belongs to another queue. The scoreboard sees this at the first dequeue of the damaged queue, usually three cycles after the enqueue concerned. A miscounted occupancy appears on the free count on the very next edge, and it changes enq_ready when the queue nears full. Faults in the arbiter or the in-flight tracking show up in other ways. They can make a streaming queue produce gaps, which breaks the exact R7 window. They can make a waiting queue miss its R8 bound. They can also make a stalled output buffer lose or overwrite data, which the R9 hold check catches within one cycle.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
    // Cycles from read issue to read data at the array output.
    localparam int RD_LAT    = 1;
    // Output slots per queue: enough to cover one word in flight plus one shown.
    localparam int OUT_SLOTS = RD_LAT + 1;
    // Width of an output-slot count.
    localparam int OCW       = $clog2(OUT_SLOTS + 1);
endpackage

// File: rtl/mqf_sram.sv
module mqf_sram #(
    parameter int W  = 16,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          wen,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          ren,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [W-1:0] mem [ENTRIES];
    logic [W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (wen) mem[waddr] <= wdata;
        if (ren) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/mqf_rr_arb.sv
module mqf_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_any
);
    localparam int IW = $clog2(N);

    typedef struct packed {
        logic [IW-1:0] last;
    } arb_st_t;

    arb_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(st_q.last) + k) % N;
            if (!gnt_any && req[idx]) begin
                gnt_any  = 1'b1;
                gnt[idx] = 1'b1;
                gnt_idx  = IW'(idx);
            end
        end
        if (gnt_any) st_d.last = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.last <= IW'(N - 1);
        else        st_q <= st_d;
    end

    assert_grant_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    assert_grant_requested_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    assert_grant_when_asked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> gnt_any);
endmodule

// File: rtl/mqf_skid.sv
module mqf_skid
    import mqf_pkg::*;
#(
    parameter int W     = 16,
    parameter int SLOTS = OUT_SLOTS
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [W-1:0]   push_data,
    input  logic           pop,
    output logic           valid,
    output logic [W-1:0]   data,
    output logic [OCW-1:0] count
);
    localparam int SPW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SPW-1:0] LASTP = SPW'(SLOTS - 1);

    typedef struct packed {
        logic [SLOTS-1:0][W-1:0] mem;
        logic [SPW-1:0]          rd;
        logic [SPW-1:0]          wr;
        logic [OCW-1:0]          cnt;
    } skid_st_t;

    skid_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == LASTP) ? '0 : st_q.wr + SPW'(1);
        end
        if (pop) begin
            st_d.rd = (st_q.rd == LASTP) ? '0 : st_q.rd + SPW'(1);
        end
        st_d.cnt = st_q.cnt + OCW'(push) - OCW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem <= '0;
            st_q.rd  <= '0;
            st_q.wr  <= '0;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid = (st_q.cnt != '0);
    assign data  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    // A returning word always finds a free slot (R7 sizing).
    assert_skid_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < OCW'(SLOTS)));

    assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> valid);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !pop) |=> (valid && $stable(data)));
endmodule

// File: rtl/mqf_bank.sv
module mqf_bank
    import mqf_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int DEPTH = 8,
    parameter int W     = 16,
    localparam int QW   = (NQ > 1) ? $clog2(NQ) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enq_valid,
    input  logic [QW-1:0]    enq_qid,
    input  logic [W-1:0]     enq_data,
    output logic             enq_ready,
    output logic [NQ-1:0]    deq_valid,
    input  logic [NQ-1:0]    deq_ready,
    output logic [NQ*W-1:0]  deq_data,
    output logic [NQ-1:0]    q_full,
    output logic [NQ-1:0]    q_empty,
    output logic [NQ*CW-1:0] q_free
);
    localparam int  PW   = $clog2(DEPTH);
    localparam int  AW   = QW + PW;
    localparam bit  POW2 = ((1 << QW) == NQ);

    typedef struct packed {
        logic [NQ-1:0][PW-1:0] tail;
        logic [NQ-1:0][PW-1:0] rptr;
        logic [NQ-1:0][CW-1:0] used;
        logic [NQ-1:0][CW-1:0] unread;
        logic [NQ-1:0]         infl;
        logic                  ret_vld;
        logic [QW-1:0]         ret_qid;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [NQ-1:0]           full;
    logic [NQ-1:0]           deq_fire;
    logic [NQ-1:0]           land;
    logic [NQ-1:0]           elig;
    logic [NQ-1:0]           enq_hit;
    logic [NQ-1:0][OCW-1:0]  ob_cnt;
    logic                    qsel_ok;
    logic                    enq_fire;
    logic [NQ-1:0]           gnt;
    logic [QW-1:0]           gnt_idx;
    logic                    gnt_any;
    logic [W-1:0]            rd_word;

    // Per-queue flags feeding the arbiter and the next-state logic.
    always_comb begin
        qsel_ok  = POW2 ? 1'b1 : (int'(enq_qid) < NQ);
        for (int i = 0; i < NQ; i++) begin
            full[i] = (st_q.used[i] == CW'(DEPTH));
        end
        enq_ready = qsel_ok && !full[enq_qid];
        enq_fire  = enq_valid && enq_ready;
        for (int i = 0; i < NQ; i++) begin
            int room;
            enq_hit[i]  = enq_fire && (enq_qid == QW'(i));
            deq_fire[i] = deq_valid[i] && deq_ready[i];
            land[i]     = st_q.ret_vld && (st_q.ret_qid == QW'(i));
            room        = int'(ob_cnt[i]) + int'(st_q.infl[i]) - int'(deq_fire[i]);
            elig[i]     = (st_q.unread[i] != '0) && (room < OUT_SLOTS);
        end
    end

    mqf_rr_arb #(.N(NQ)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (elig),
        .gnt     (gnt),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    mqf_sram #(.W(W), .AW(AW)) u_mem (
        .clk   (clk),
        .wen   (enq_fire),
        .waddr ({enq_qid, st_q.tail[enq_qid]}),
        .wdata (enq_data),
        .ren   (gnt_any),
        .raddr ({gnt_idx, st_q.rptr[gnt_idx]}),
        .rdata (rd_word)
    );

    // Next state of the pointer and count registers.
    always_comb begin
        st_d = st_q;
        if (enq_fire) st_d.tail[enq_qid] = st_q.tail[enq_qid] + PW'(1);
        if (gnt_any)  st_d.rptr[gnt_idx] = st_q.rptr[gnt_idx] + PW'(1);
        for (int i = 0; i < NQ; i++) begin
            st_d.used[i]   = st_q.used[i] + CW'(enq_hit[i]) - CW'(deq_fire[i]);
            st_d.unread[i] = st_q.unread[i] + CW'(enq_hit[i]) - CW'(gnt[i]);
            st_d.infl[i]   = gnt[i] | (st_q.infl[i] & ~land[i]);
        end
        st_d.ret_vld = gnt_any;
        st_d.ret_qid = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tail    <= '0;
            st_q.rptr    <= '0;
            st_q.used    <= '0;
            st_q.unread  <= '0;
            st_q.infl    <= '0;
            st_q.ret_vld <= 1'b0;
            st_q.ret_qid <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NQ; i++) begin : g_q
        mqf_skid #(.W(W), .SLOTS(OUT_SLOTS)) u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (land[i]),
            .push_data (rd_word),
            .pop       (deq_fire[i]),
            .valid     (deq_valid[i]),
            .data      (deq_data[i*W +: W]),
            .count     (ob_cnt[i])
        );

        assign q_full[i]          = full[i];
        assign q_empty[i]         = (st_q.used[i] == '0);
        assign q_free[i*CW +: CW] = CW'(DEPTH) - st_q.used[i];

        assert_used_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.used[i] <= CW'(DEPTH));

        assert_net_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (enq_hit[i] && deq_fire[i]) |=> $stable(st_q.used[i]));

        assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (full[i] && enq_qid == QW'(i)) |-> !enq_fire);
    end

    assert_issue_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> (st_q.unread[gnt_idx] != '0));
endmodule

// File: tb/mqf_bank_test.sv
module mqf_bank_test;
    localparam int NQ    = 4;
    localparam int DEPTH = 8;
    localparam int W     = 16;
    localparam int QW    = 2;
    localparam int CW    = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic             enq_valid;
    logic [QW-1:0]    enq_qid;
    logic [W-1:0]     enq_data;
    logic             enq_ready;
    logic [NQ-1:0]    deq_valid;
    logic [NQ-1:0]    deq_ready;
    logic [NQ*W-1:0]  deq_data;
    logic [NQ-1:0]    q_full;
    logic [NQ-1:0]    q_empty;
    logic [NQ*CW-1:0] q_free;

    mqf_bank #(.NQ(NQ), .DEPTH(DEPTH), .W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .enq_qid   (enq_qid),
        .enq_data  (enq_data),
        .enq_ready (enq_ready),
        .deq_valid (deq_valid),
        .deq_ready (deq_ready),
        .deq_data  (deq_data),
        .q_full    (q_full),
        .q_empty   (q_empty),
        .q_free    (q_free)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [W-1:0] exp_q [NQ][$];
    logic [W-1:0] next_word = 16'h0100;
    int first_fire [NQ];
    int last_fire  [NQ];
    int fire_cnt   [NQ];

    typedef struct packed {
        logic       ev;
        logic [1:0] q;
        logic [3:0] rdy;
        logic [7:0] reps;
        logic       chk;
        logic [1:0] cq;
        logic [4:0] exp_used;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t TBL [NROWS] = '{
        '{1'b1, 2'd0, 4'b0000, 8'd3,  1'b1, 2'd0, 5'd3},  // fill q0 partly
        '{1'b1, 2'd1, 4'b0000, 8'd8,  1'b1, 2'd1, 5'd8},  // fill q1 to full
        '{1'b1, 2'd1, 4'b0000, 8'd3,  1'b1, 2'd1, 5'd8},  // offers to full q1 refused
        '{1'b1, 2'd2, 4'b0100, 8'd6,  1'b0, 2'd2, 5'd0},  // q2 flows through
        '{1'b0, 2'd0, 4'b0001, 8'd12, 1'b1, 2'd0, 5'd0},  // q0 drains, q1 still full
        '{1'b0, 2'd0, 4'b0000, 8'd1,  1'b1, 2'd1, 5'd8},
        '{1'b1, 2'd2, 4'b1111, 8'd4,  1'b0, 2'd2, 5'd0},
        '{1'b0, 2'd0, 4'b1111, 8'd20, 1'b1, 2'd1, 5'd0},
        '{1'b0, 2'd0, 4'b1111, 8'd2,  1'b1, 2'd2, 5'd0}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int free_of(input int q);
        return int'(q_free[q*CW +: CW]);
    endfunction

    task automatic chk_status(input int q, input string req);
        int sz;
        sz = exp_q[q].size();
        chk(free_of(q) == DEPTH - sz, req, $sformatf("free count q%0d", q), free_of(q), DEPTH - sz);
        chk(q_full[q] == (sz == DEPTH), req, $sformatf("full flag q%0d", q), q_full[q], sz == DEPTH);
        chk(q_empty[q] == (sz == 0), req, $sformatf("empty flag q%0d", q), q_empty[q], sz == 0);
    endtask

    // One cycle: drive at the falling edge, sample 1 ns later, then wait.
    task automatic step(input bit ev, input int q, input logic [NQ-1:0] rdy);
        enq_valid = ev;
        enq_qid   = QW'(q);
        enq_data  = next_word;
        deq_ready = rdy;
        #1;
        if (ev && exp_q[q].size() == DEPTH)
            chk(enq_ready == 1'b0, "R2", "enq_ready on full queue", enq_ready, 0);
        for (int k = 0; k < NQ; k++) begin
            if (deq_valid[k] && rdy[k]) begin
                if (exp_q[k].size() == 0) begin
                    chk(1'b0, "R3", $sformatf("unexpected word q%0d", k), deq_data[k*W +: W], -1);
                end else begin
                    chk(deq_data[k*W +: W] == exp_q[k][0], "R3",
                        $sformatf("order q%0d", k), deq_data[k*W +: W], exp_q[k][0]);
                    void'(exp_q[k].pop_front());
                end
                fire_cnt[k]++;
                if (first_fire[k] < 0) first_fire[k] = cyc;
                last_fire[k] = cyc;
            end
        end
        if (ev && enq_ready) begin
            exp_q[q].push_back(next_word);
            next_word = next_word + 16'd1;
        end
        @(negedge clk);
        cyc++;
    endtask

    task automatic clear_track();
        for (int k = 0; k < NQ; k++) begin
            first_fire[k] = -1;
            last_fire[k]  = -1;
            fire_cnt[k]   = 0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int t;
        logic [W-1:0] held;
        rst_n     = 1'b0;
        enq_valid = 1'b0;
        enq_qid   = '0;
        enq_data  = '0;
        deq_ready = '0;
        clear_track();
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        for (int k = 0; k < NQ; k++) begin
            chk(free_of(k) == DEPTH, "R1", "free after reset", free_of(k), DEPTH);
            chk(q_empty[k] == 1'b1, "R1", "empty after reset", q_empty[k], 1);
            chk(q_full[k] == 1'b0, "R1", "full after reset", q_full[k], 0);
            chk(deq_valid[k] == 1'b0, "R1", "deq_valid after reset", deq_valid[k], 0);
        end
        chk(enq_ready == 1'b1, "R1", "enq_ready after reset", enq_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2, R3, R4, R10
        for (int r = 0; r < NROWS; r++) begin
            for (int k = 0; k < int'(TBL[r].reps); k++)
                step(TBL[r].ev, int'(TBL[r].q), TBL[r].rdy);
            if (TBL[r].chk) begin
                chk(free_of(int'(TBL[r].cq)) == DEPTH - int'(TBL[r].exp_used),
                    (r == 4) ? "R10" : "R4", $sformatf("table row %0d free", r),
                    free_of(int'(TBL[r].cq)), DEPTH - int'(TBL[r].exp_used));
                chk_status(int'(TBL[r].cq), "R4");
            end
        end

        // R6: latency from acceptance to first offer
        repeat (4) step(1'b0, 0, '1);
        clear_track();
        t = cyc;
        step(1'b1, 2, '1);
        repeat (6) step(1'b0, 0, '1);
        chk(first_fire[2] == t + 3, "R6", "first offer cycle", first_fire[2], t + 3);

        // R7: one queue streams at full rate
        clear_track();
        t = cyc;
        for (int k = 0; k < 8; k++) step(1'b1, 0, '1);
        repeat (8) step(1'b0, 0, '1);
        chk(first_fire[0] == t + 3, "R7", "stream start", first_fire[0], t + 3);
        chk(last_fire[0] == t + 10, "R7", "stream end", last_fire[0], t + 10);
        chk(fire_cnt[0] == 8, "R7", "stream words", fire_cnt[0], 8);

        // R8: a waiting queue is served while another streams
        clear_track();
        for (int k = 0; k < 6; k++) step(1'b1, 0, '1);
        t = cyc;
        step(1'b1, 3, '1);
        for (int k = 0; k < 4; k++) step(1'b1, 0, '1);
        repeat (10) step(1'b0, 0, '1);
        chk(first_fire[3] >= t + 3 && first_fire[3] <= t + 3 + NQ, "R8",
            "waiting queue offer cycle", first_fire[3], t + 3 + NQ);

        // R9: stalled consumer keeps data stable
        step(1'b1, 1, '0);
        repeat (4) step(1'b0, 0, '0);
        #1;
        held = deq_data[1*W +: W];
        chk(deq_valid[1] == 1'b1, "R9", "valid while stalled", deq_valid[1], 1);
        chk(held == exp_q[1][0], "R9", "stalled head word", held, exp_q[1][0]);
        step(1'b0, 0, '0);
        #1;
        chk(deq_valid[1] == 1'b1, "R9", "valid still held", deq_valid[1], 1);
        chk(deq_data[1*W +: W] == held, "R9", "data held", deq_data[1*W +: W], held);
        repeat (4) step(1'b0, 0, '1);

        // R5: simultaneous enqueue and dequeue on one queue
        for (int k = 0; k < 3; k++) step(1'b1, 3, '0);
        repeat (4) step(1'b0, 0, '0);
        chk(free_of(3) == DEPTH - 3, "R5", "free before", free_of(3), DEPTH - 3);
        step(1'b1, 3, 4'b1000);
        chk(free_of(3) == DEPTH - 3, "R5", "free after enq+deq", free_of(3), DEPTH - 3);

        // Final drain: everything delivered
        repeat (20) step(1'b0, 0, '1);
        for (int k = 0; k < NQ; k++) begin
            chk(exp_q[k].size() == 0, "R3", $sformatf("words left q%0d", k), exp_q[k].size(), 0);
            chk_status(k, "R4");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule